// File: doc/BRIEF.md
# Dice-Pair Occurrence Tally

This block keeps a running tally of how often each ordered pair of die faces has been rolled. It holds one multi-byte counter for each pair in an internal register table. At reset it fills that table from an external nonvolatile byte store. When a roll arrives it increments the matching counter, one byte per cycle, starting at the least significant byte. It then writes back only the bytes it changed.

The store is reached through a single byte-wide request/ready port that serves both the reset-time reads and the write-backs. A roll is offered with `roll_valid` together with two face values. The block accepts it in a cycle where `roll_ready` is high. It drops that signal while the table is loading and while a write-back is still outstanding, so a caller that keeps `roll_valid` asserted simply waits.

Top module: `dice_tally`

## Requirements
- R1: The table has FACES×FACES entries of CNT_BYTES bytes each (36 × 3 = 108 bytes by default). The entry index is FACES×roll_a + roll_b. The byte offset of the entry is CNT_BYTES × index, with the least significant byte at the lowest offset. Every table byte uses its offset as its store address.
- R2: A roll is accepted on a rising clock edge where both `roll_valid` and `roll_ready` are high. The selected counter then grows by exactly one, modulo 2^(8×CNT_BYTES).
- R3: Byte k+1 of a counter is modified only when byte k has just wrapped from 0xFF to 0x00. Every written byte except the highest-addressed one in a write-back therefore carries 0x00.
- R4: The number of bytes written back for a roll equals the number of bytes the increment touched (1, 2 or 3). No other store writes occur.
- R5: The write-back starts at the highest touched address and steps down by one address for each completed store transfer.
- R6: After reset the block reads store addresses 0 up to 107 in ascending order, one read per completed transfer. It places each returned byte into the table.
- R7: `roll_ready` is low from reset until the last load read has completed.
- R8: `roll_ready` stays low from a roll's acceptance until the final byte of its write-back has completed. A roll held valid during that time is accepted afterwards.
- R9: A counter at its maximum value (0xFFFFFF) wraps to zero. All three of its bytes are written back as 0x00.
- R10: A roll with either face value at FACES or above is accepted but ignored. No counter changes and no store write follows.
- R11: `nv_req` stays high, with `nv_addr`, `nv_we` and `nv_wdata` unchanged, until a cycle in which `nv_ready` is high. That cycle completes the transfer. `nv_we` is 1 for a write and 0 for a read. Read data on `nv_rdata` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| roll_valid | input | 1 | A roll is offered |
| roll_a | input | FW (3) | First die face, 0-based |
| roll_b | input | FW (3) | Second die face, 0-based |
| roll_ready | output | 1 | Block can accept a roll |
| nv_req | output | 1 | Store transfer requested |
| nv_we | output | 1 | 1 = write, 0 = read |
| nv_addr | output | AW (7) | Store byte address |
| nv_wdata | output | 8 | Byte to write |
| nv_rdata | input | 8 | Byte read from store |
| nv_ready | input | 1 | Store completes the current transfer |

## Verification
The bench builds the block with its defaults: six faces and three-byte counters. It gives the store model a preloaded image with counters whose low byte is 0xFF, whose two low bytes are 0xFFFF, and one at 0xFFFFFF. This brings two-byte and three-byte carry ripples, and the full wrap, within reach in a few rolls instead of millions. Store latency varies from zero to three cycles, so both back-to-back and stretched handshakes occur. Rolls held during a pending write-back exercise the wait path.

// File: rtl/dice_cnt_pkg.sv
package dice_cnt_pkg;
    typedef enum logic [1:0] {
        ST_LOAD,
        ST_IDLE,
        ST_INC,
        ST_WB
    } dc_state_e;
endpackage

// File: rtl/dice_index.sv
module dice_index #(
    parameter int FACES     = 6,
    parameter int CNT_BYTES = 3,
    parameter int FW        = 3,
    parameter int AW        = 7
) (
    input  logic [FW-1:0] face_a,
    input  logic [FW-1:0] face_b,
    output logic [AW-1:0] base_off,
    output logic          in_range
);
    always_comb begin
        int unsigned idx;
        in_range = (32'(face_a) < FACES) && (32'(face_b) < FACES);
        idx      = 32'(face_a) * FACES + 32'(face_b);
        base_off = in_range ? AW'(idx * CNT_BYTES) : '0;
    end
endmodule

// File: rtl/dice_table.sv
module dice_table #(
    parameter int DEPTH = 108,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wr_data,
    output logic [7:0]    rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/dice_tally.sv
module dice_tally
    import dice_cnt_pkg::*;
#(
    parameter  int FACES     = 6,
    parameter  int CNT_BYTES = 3,
    localparam int FW        = (FACES > 1) ? $clog2(FACES + 1) : 1,
    localparam int DEPTH     = FACES * FACES * CNT_BYTES,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          roll_valid,
    input  logic [FW-1:0] roll_a,
    input  logic [FW-1:0] roll_b,
    output logic          roll_ready,
    output logic          nv_req,
    output logic          nv_we,
    output logic [AW-1:0] nv_addr,
    output logic [7:0]    nv_wdata,
    input  logic [7:0]    nv_rdata,
    input  logic          nv_ready
);
    localparam int KW   = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;
    localparam int LAST = DEPTH - 1;

    typedef struct packed {
        dc_state_e     st;
        logic [AW-1:0] addr;
        logic [KW-1:0] k;
    } regs_t;

    regs_t         d, q;
    logic [AW-1:0] base_off;
    logic          in_range;
    logic          tbl_we;
    logic [7:0]    tbl_wd;
    logic [7:0]    tbl_rd;

    dice_index #(
        .FACES(FACES), .CNT_BYTES(CNT_BYTES), .FW(FW), .AW(AW)
    ) u_index (
        .face_a(roll_a), .face_b(roll_b),
        .base_off(base_off), .in_range(in_range)
    );

    dice_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk(clk), .wr_en(tbl_we), .addr(q.addr),
        .wr_data(tbl_wd), .rd_data(tbl_rd)
    );

    always_comb begin
        d      = q;
        tbl_we = 1'b0;
        tbl_wd = nv_rdata;
        case (q.st)
            ST_LOAD: begin
                if (nv_ready) begin
                    tbl_we = 1'b1;
                    if (q.addr == AW'(LAST)) begin
                        d.st   = ST_IDLE;
                        d.addr = '0;
                    end else begin
                        d.addr = q.addr + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (roll_valid && in_range) begin
                    d.st   = ST_INC;
                    d.addr = base_off;
                    d.k    = '0;
                end
            end
            ST_INC: begin
                tbl_we = 1'b1;
                tbl_wd = tbl_rd + 8'd1;
                if (tbl_wd == 8'd0 && q.k != KW'(CNT_BYTES - 1)) begin
                    d.k    = q.k + 1'b1;
                    d.addr = q.addr + 1'b1;
                end else begin
                    d.st = ST_WB;
                end
            end
            ST_WB: begin
                if (nv_ready) begin
                    if (q.k == '0) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.k    = q.k - 1'b1;
                        d.addr = q.addr - 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_LOAD, addr: '0, k: '0};
        end else begin
            q <= d;
        end
    end

    assign roll_ready = (q.st == ST_IDLE);
    assign nv_req     = (q.st == ST_LOAD) || (q.st == ST_WB);
    assign nv_we      = (q.st == ST_WB);
    assign nv_addr    = q.addr;
    assign nv_wdata   = tbl_rd;

    // R6
    load_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && !nv_we && nv_ready && nv_addr != AW'(LAST))
        |=> (nv_addr == AW'($past(nv_addr) + 1'b1)));

    // R5
    wb_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_we && nv_ready)
        |=> (!(nv_req && nv_we) || nv_addr == AW'($past(nv_addr) - 1'b1)));

    // R3
    wb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && nv_we && nv_ready) |=> (!(nv_req && nv_we) || nv_wdata == 8'd0));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req && !nv_ready)
        |=> (nv_req && $stable(nv_addr) && $stable(nv_we) && $stable(nv_wdata)));

    // R8
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_valid && roll_ready && in_range) |=> !roll_ready);
endmodule

// File: tb/dice_tally_bench.sv
module dice_tally_bench;
    localparam int FACES = 6;
    localparam int CB    = 3;
    localparam int DEPTH = FACES * FACES * CB;
    localparam int FW    = 3;
    localparam int AW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          roll_valid = 1'b0;
    logic [FW-1:0] roll_a = '0;
    logic [FW-1:0] roll_b = '0;
    logic          roll_ready;
    logic          nv_req, nv_we;
    logic [AW-1:0] nv_addr;
    logic [7:0]    nv_wdata;
    logic [7:0]    nv_rdata = '0;
    logic          nv_ready = 1'b0;

    always #2.5 clk = ~clk;

    dice_tally u_dice_tally (
        .clk(clk), .rst_n(rst_n), .roll_valid(roll_valid),
        .roll_a(roll_a), .roll_b(roll_b), .roll_ready(roll_ready),
        .nv_req(nv_req), .nv_we(nv_we), .nv_addr(nv_addr),
        .nv_wdata(nv_wdata), .nv_rdata(nv_rdata), .nv_ready(nv_ready)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] store [DEPTH];
    logic [7:0] model [DEPTH];
    int         exp_q[$];
    int         load_idx = 0;
    int         wr_cnt = 0;
    int         wait_cnt = 0;
    int         lat = 0;
    bit         done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // store model and monitor
    always @(negedge clk) begin
        nv_ready <= 1'b0;
        if (rst_n && nv_req && !nv_ready) begin
            if (wait_cnt >= lat) begin
                nv_ready <= 1'b1;
                wait_cnt <= 0;
                lat      <= (lat + 1) % 4;
                if (nv_we) begin
                    int got;
                    got = {16'd0, 1'b0, nv_addr, nv_wdata};
                    store[nv_addr] <= nv_wdata;
                    wr_cnt++;
                    chk(!roll_ready, "R8", roll_ready, 0);
                    if (exp_q.size() == 0) begin
                        chk(0, "R4", got, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(got[14:8] == e[14:8], "R5", got[14:8], e[14:8]);
                        chk(got[7:0] == e[7:0], "R3", got[7:0], e[7:0]);
                    end
                end else begin
                    nv_rdata <= store[nv_addr];
                    chk(32'(nv_addr) == load_idx, "R6", nv_addr, load_idx);
                    load_idx++;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic roll(input int a, input int b);
        @(negedge clk);
        roll_valid = 1'b1;
        roll_a     = FW'(a);
        roll_b     = FW'(b);
        while (!roll_ready) @(negedge clk);
        if (a < FACES && b < FACES) begin
            int base, n;
            logic [23:0] v;
            base = (a * FACES + b) * CB;
            v = {model[base+2], model[base+1], model[base]} + 24'd1;
            n = 1;
            if (v[7:0] == 8'd0) n = 2;
            if (v[15:0] == 16'd0) n = 3;
            for (int i = 0; i < CB; i++) model[base+i] = v[8*i +: 8];
            for (int k = n - 1; k >= 0; k--) exp_q.push_back(((base + k) << 8) | v[8*k +: 8]);
        end
        @(negedge clk);
        roll_valid = 1'b0;
    endtask

    task automatic drain;
        int t;
        t = 0;
        while ((exp_q.size() != 0 || !roll_ready) && t < 200) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) store[i] = 8'((i * 37 + 11) & 255);
        store[0] = 8'h00; store[1] = 8'h00; store[2] = 8'h00;
        store[39] = 8'hFF; store[40] = 8'h12; store[41] = 8'h00;   // entry 13
        store[66] = 8'hFF; store[67] = 8'hFF; store[68] = 8'h00;   // entry 22
        store[105] = 8'hFF; store[106] = 8'hFF; store[107] = 8'hFF; // entry 35
        for (int i = 0; i < DEPTH; i++) model[i] = store[i];
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!roll_ready, "R7", roll_ready, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(!roll_ready, "R7", roll_ready, 0);
        while (!roll_ready) @(negedge clk);
        chk(load_idx == DEPTH, "R6", load_idx, DEPTH);
        roll(0, 0);                       // R2 single byte
        roll(0, 0);
        roll(2, 1);                       // R3 two bytes
        roll(3, 4);                       // R4 three bytes
        roll(5, 5);                       // R9 full wrap
        drain();
        chk(store[105] == 0 && store[106] == 0 && store[107] == 0, "R9",
            {store[107], store[106], store[105]}, 0);
        roll(5, 5);
        drain();
        begin
            int w0;
            w0 = wr_cnt;
            roll(6, 2);                   // R10 ignored
            roll(1, 7);
            repeat (10) @(negedge clk);
            chk(wr_cnt == w0, "R10", wr_cnt, w0);
            chk(roll_ready, "R10", roll_ready, 1);
        end
        for (int i = 0; i < 24; i++) roll((i * 5) % 6, (i * 7 + 1) % 6); // R8 back-to-back
        drain();
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        for (int i = 0; i < DEPTH; i++) chk(store[i] == model[i], "R1", store[i], model[i]);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule